// File: doc/BRIEF.md
# Local Bus Interrupt Encoder

This block gathers a set of level-sensitive interrupt request lines from peripherals on a local bus, holds them in a source register, and gates that register with a software-programmed enable mask. Any surviving request drives a single combined interrupt output toward the processor.

Software reaches the block through a small 16-bit register port. One offset returns an encoded vector naming the lowest-numbered pending, enabled source, scaled so that it can index a table of 4-byte entries directly. A second offset holds the enable mask, which comes out of reset with only source 4 enabled. Other offsets read as zero and ignore writes. The asynchronous reset input is released through an internal synchronizer before it reaches the registers.

Top module: `lbi_intr_encoder`

## Requirements
- R1: Source bit i follows request line i: one clock after the line is sampled high the bit is set, and one clock after it is sampled low the bit is clear.
- R2: `irq_out` is registered and equals the OR of (source AND mask); it changes at the first clock edge after a request line changes, and not before.
- R3: A read at offset 0x000 returns (i+1)*4, where i is the lowest-numbered bit set in (source AND mask), and returns 0 when that AND is zero; bits [1:0] of a vector are always 0.
- R4: Offset 0x002 holds the 16-bit enable mask (bit i enables source i); it reads back what was written, and a write changes `irq_out` at the same clock edge that loads the mask.
- R5: After reset the mask reads 0x0010, the vector reads 0 and `irq_out` is 0.
- R6: Only address bits [11:0] are decoded; bits above them are ignored for both reads and writes.
- R7: Reads at any decoded offset other than 0x000 and 0x002 return 0, and writes there leave the mask unchanged.
- R8: Reading the vector has no effect on the source bits, the mask or `irq_out`.
- R9: When several enabled sources are pending, the vector names the lowest-numbered one regardless of which others are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 16 | Level-sensitive request lines, bit i is source i |
| bus_addr | input | 16 | Register address; only bits [11:0] are decoded |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; data loads at the next clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data; zero when `bus_rd` is low |
| irq_out | output | 1 | Combined interrupt, high while any enabled source is pending |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle, that request lines are synchronous to `clk`, and that nothing is judged in the first cycle after the internal reset is released. The stimulus drives every input on the falling edge, issues reads and writes as separate single-cycle strobes, and waits several cycles after reset before the first access. Sweeps cover every single source, every ordered pair of sources, and a family of masks that move the lowest enabled bit across all sixteen positions.

// File: rtl/lbi_pkg.sv
package lbi_pkg;
  localparam int LBI_DEC_AW = 12;
  localparam logic [LBI_DEC_AW-1:0] LBI_OFF_VEC  = 12'h000;
  localparam logic [LBI_DEC_AW-1:0] LBI_OFF_MASK = 12'h002;
  localparam int LBI_VEC_SHIFT = 2;

  typedef enum logic [1:0] {
    LBI_REG_NONE = 2'd0,
    LBI_REG_VEC  = 2'd1,
    LBI_REG_MASK = 2'd2
  } lbi_reg_e;
endpackage

// File: rtl/lbi_rst_sync.sv
module lbi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lbi_source_latch.sv
module lbi_source_latch #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines,
  output logic [NUM_SRC-1:0] src_q
);
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      logic bit_d;
      logic bit_en;
      always_comb begin
        bit_d  = irq_lines[g];
        bit_en = (bit_d != src_q[g]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      src_q[g] <= 1'b0;
        else if (bit_en) src_q[g] <= bit_d;
      end
    end
  endgenerate
endmodule

// File: rtl/lbi_first_pending.sv
module lbi_first_pending #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  vec_code
);
  import lbi_pkg::*;
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0] idx;
  logic             any;

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pend[k]) begin
        idx = IDX_W'(k);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    if (any) vec_code = (DATA_W'(idx) + DATA_W'(1)) << LBI_VEC_SHIFT;
    else     vec_code = '0;
  end
endmodule

// File: rtl/lbi_csr.sv
module lbi_csr #(
  parameter int                   NUM_SRC  = 16,
  parameter int                   DATA_W   = 16,
  parameter int                   BUS_AW   = 16,
  parameter logic [NUM_SRC-1:0]   MASK_RST = 16'h0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  vec_code,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_d,
  output logic [DATA_W-1:0]  bus_rdata
);
  import lbi_pkg::*;

  logic [LBI_DEC_AW-1:0] addr_lo;
  lbi_reg_e              reg_sel;
  logic                  mask_en;

  assign addr_lo = bus_addr[LBI_DEC_AW-1:0];

  always_comb begin
    unique case (addr_lo)
      LBI_OFF_VEC:  reg_sel = LBI_REG_VEC;
      LBI_OFF_MASK: reg_sel = LBI_REG_MASK;
      default:      reg_sel = LBI_REG_NONE;
    endcase
  end

  always_comb begin
    mask_en = bus_wr && (reg_sel == LBI_REG_MASK);
    mask_d  = mask_en ? bus_wdata[NUM_SRC-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RST;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (reg_sel)
        LBI_REG_VEC:  bus_rdata = vec_code;
        LBI_REG_MASK: bus_rdata = DATA_W'(mask_q);
        default:      bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lbi_intr_encoder.sv
module lbi_intr_encoder #(
  parameter int                 NUM_SRC  = 16,
  parameter int                 DATA_W   = 16,
  parameter int                 BUS_AW   = 16,
  parameter logic [NUM_SRC-1:0] MASK_RST = 16'h0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0] pend;
  logic [DATA_W-1:0]  vec_code;
  logic               irq_d;
  logic               irq_en;

  lbi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lbi_source_latch #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst_n(rst_sync_n), .irq_lines(irq_lines), .src_q(src_q)
  );

  assign pend = src_q & mask_q;

  lbi_first_pending #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_enc (
    .pend(pend), .vec_code(vec_code)
  );

  lbi_csr #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .BUS_AW(BUS_AW),
            .MASK_RST(MASK_RST)) u_csr (
    .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .vec_code(vec_code),
    .mask_q(mask_q), .mask_d(mask_d), .bus_rdata(bus_rdata)
  );

  always_comb begin
    irq_d  = |(irq_lines & mask_d);
    irq_en = (irq_d != irq_out);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  irq_out <= 1'b0;
    else if (irq_en)  irq_out <= irq_d;
  end
endmodule

// File: rtl/lbi_intr_checker.sv
module lbi_intr_checker #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_lines,
  input logic [NUM_SRC-1:0] src_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_out,
  input logic [11:0]        addr_lo,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_src_follow_r1: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    src_q == $past(irq_lines));

  p_irq_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(src_q & mask_q));

  p_vec_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && addr_lo == 12'h000) |-> (((bus_rdata == '0) == !irq_out) && (bus_rdata[1:0] == 2'b00)));

  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr_lo == 12'h002) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

  p_unmapped_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && addr_lo != 12'h000 && addr_lo != 12'h002) |-> (bus_rdata == '0));

  p_unmapped_write_r7: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (bus_wr && addr_lo != 12'h002) |=> $stable(mask_q));

  p_read_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (bus_rd && !bus_wr) |=> $stable(mask_q));
endmodule

bind lbi_intr_encoder lbi_intr_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq_lines(irq_lines), .src_q(src_q),
  .mask_q(mask_q), .irq_out(irq_out), .addr_lo(bus_addr[11:0]),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/lbi_intr_encoder_bench.sv
module lbi_intr_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lbi_intr_encoder u_lbi_intr_encoder (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [15:0] exp_vec(logic [15:0] v);
    for (int k = 0; k < 16; k++) if (v[k]) return 16'((k + 1) * 4);
    return 16'h0000;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_lines(logic [15:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
  endtask

  task automatic reg_write(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: reset state
    chk("R5 irq_out", 16'(irq_out), 16'h0);
    reg_read(16'h0002, rd); chk("R5 mask", rd, 16'h0010);
    reg_read(16'h0000, rd); chk("R5 vec", rd, 16'h0000);

    // R5: only source 4 enabled after reset
    drive_lines(16'h0008);
    chk("R5 src3 masked irq", 16'(irq_out), 16'h0);
    reg_read(16'h0000, rd); chk("R5 src3 masked vec", rd, 16'h0000);
    drive_lines(16'h0010);
    chk("R5 src4 irq", 16'(irq_out), 16'h1);
    reg_read(16'h0000, rd); chk("R5 src4 vec", rd, 16'd20);

    // R4: mask write and readback
    reg_write(16'h0002, 16'hFFFF);
    reg_read(16'h0002, rd); chk("R4 mask readback", rd, 16'hFFFF);

    // R1 R3: every single source, then release
    for (int i = 0; i < 16; i++) begin
      drive_lines(16'(1) << i);
      chk("R1 single irq", 16'(irq_out), 16'h1);
      reg_read(16'h0000, rd); chk("R3 single vec", rd, 16'((i + 1) * 4));
      drive_lines(16'h0000);
      chk("R1 release irq", 16'(irq_out), 16'h0);
      reg_read(16'h0000, rd); chk("R1 release vec", rd, 16'h0000);
    end

    // R9: every pair of sources
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        v = (16'(1) << a) | (16'(1) << b);
        drive_lines(v);
        reg_read(16'h0000, rd); chk("R9 pair vec", rd, exp_vec(v));
      end
    end

    // R4 R3: masks moving the lowest enabled bit, all lines high
    drive_lines(16'hFFFF);
    for (int k = 0; k < 16; k++) begin
      reg_write(16'h0002, 16'hFFFF << k);
      reg_read(16'h0002, rd); chk("R4 mask sweep readback", rd, 16'hFFFF << k);
      reg_read(16'h0000, rd); chk("R4 mask sweep vec", rd, 16'((k + 1) * 4));
      chk("R4 mask sweep irq", 16'(irq_out), 16'h1);
    end
    reg_write(16'h0002, 16'h0000);
    chk("R4 zero mask irq", 16'(irq_out), 16'h0);
    reg_read(16'h0000, rd); chk("R4 zero mask vec", rd, 16'h0000);

    // R2: registered output timing
    reg_write(16'h0002, 16'hFFFF);
    drive_lines(16'h0000);
    @(negedge clk);
    irq_lines = 16'h0080;
    #1 chk("R2 before edge", 16'(irq_out), 16'h0);
    @(posedge clk); #1 chk("R2 after edge", 16'(irq_out), 16'h1);

    // R4: mask write takes effect at the loading edge
    @(negedge clk);
    bus_addr = 16'h0002; bus_wdata = 16'h0000; bus_wr = 1'b1;
    #1 chk("R4 before edge", 16'(irq_out), 16'h1);
    @(posedge clk); #1 chk("R4 at edge", 16'(irq_out), 16'h0);
    @(negedge clk); bus_wr = 1'b0;

    // R6: upper address bits ignored
    reg_write(16'hF002, 16'h00A0);
    reg_read(16'h3002, rd); chk("R6 mask alias", rd, 16'h00A0);
    drive_lines(16'h0020);
    reg_read(16'h5000, rd); chk("R6 vec alias", rd, 16'd24);

    // R7: unmapped offsets
    reg_write(16'h0004, 16'h0000);
    reg_write(16'h0003, 16'h0000);
    reg_write(16'h0FFE, 16'h0000);
    reg_read(16'h0002, rd); chk("R7 mask untouched", rd, 16'h00A0);
    chk("R7 irq untouched", 16'(irq_out), 16'h1);
    reg_read(16'h0004, rd); chk("R7 read 004", rd, 16'h0000);
    reg_read(16'h0001, rd); chk("R7 read 001", rd, 16'h0000);
    reg_read(16'h0FFE, rd); chk("R7 read FFE", rd, 16'h0000);

    // R8: repeated vector reads change nothing
    for (int n = 0; n < 4; n++) begin
      reg_read(16'h0000, rd); chk("R8 repeat vec", rd, 16'd24);
      chk("R8 irq", 16'(irq_out), 16'h1);
    end
    reg_read(16'h0002, rd); chk("R8 mask", rd, 16'h00A0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule